// File: doc/BRIEF.md
# SDRAM Bank Timing and Refresh Controller

This block turns a stream of read and write requests into the command sequence for a single-rank, four-bank single-data-rate SDRAM. Each request carries a bank, a row and a column. The controller keeps track of which row is open in each bank. Depending on that state it issues an activation, a precharge followed by an activation, or a column command straight away. Each request is retired when its column command is issued.

Every bank keeps its own row-to-column and precharge windows. A window still running in one bank never holds back a command to another bank.

A free-running interval counter marks a refresh as due. Once any data burst in flight has ended, the controller closes every open bank, one per cycle and lowest index first. It waits out the precharge delay, issues the refresh, and then stays silent for the refresh cycle time. The controller also tags returned read data with the originating bank. The tag is asserted for one full burst, beginning two or three cycles after the READ command, as set by a configuration input.

Top module: `sdram_cmd_sched`

## Requirements
- R1: The command output is a 4-bit code, written as {chip-select, row-strobe, column-strobe, write-enable}, all active low. The codes are: idle 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001. Right after reset the code is idle, `req_ready` is low and no read beat is flagged.
- R2: A request to a bank with no open row produces an activate carrying the bank and row. The column command to that bank comes no sooner than TRCD cycles after the activate, and exactly TRCD cycles after it when nothing else competes.
- R3: A request whose row is already open in its bank gets only a read (or write, when `req_write`=1) carrying the column. No activate or precharge is issued.
- R4: A request to a bank that has a different row open first gets a precharge to that bank. The activate follows exactly TRP cycles after the precharge, and is never sooner than that.
- R5: Column commands are at least BURST cycles apart. A precharge is withheld until the burst of the last column command has ended, so it comes exactly BURST cycles after that command.
- R6: After a read, `rd_beat_valid` is high for BURST consecutive cycles, beginning 2 cycles after the READ when `cfg_cas3`=0 and 3 cycles after it when `cfg_cas3`=1. During those cycles `rd_beat_bank` shows the read's bank. A write raises no beat.
- R7: Two reads to open rows, requested back to back, are issued BURST cycles apart, and their beats form one unbroken run.
- R8: A refresh becomes due every REFI cycles. The default of 976 cycles at 125 MHz gives 8192 refreshes in under 64 ms.
- R9: When a refresh is due and no burst is running, every open bank is precharged, one per cycle in ascending bank order. The refresh follows TRP cycles after the last of those precharges. It is only issued when every bank is closed.
- R10: After a refresh, only idle codes appear for TRFC cycles. A request waiting in that time is acted on exactly TRFC cycles after the refresh.
- R11: `req_ready` is high in exactly the cycle whose closing edge registers the request's column command. That command is visible in the following cycle.
- R12: Bank windows are independent. An activate to a closed bank may follow a column command to another bank in the very next cycle, and precharges to different banks may occupy consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cas3 | input | 1 | Read latency select: 0 gives 2 cycles, 1 gives 3 cycles |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_ready | output | 1 | The request is retired at the coming edge |
| cmd_code | output | 4 | Registered command code (R1) |
| cmd_bank | output | BANK_W | Bank of the registered command |
| cmd_addr | output | ADDR_W | Row for an activate, column for a read or write |
| rd_beat_valid | output | 1 | A read data beat is due on the bus this cycle |
| rd_beat_bank | output | BANK_W | Bank the current read beat belongs to |

## Verification
The bench sweeps every bank, both read latencies and both directions through a closed-bank access, an open-row hit and a row miss. From the logged command cycles it checks the exact TRCD, TRP and BURST gaps. A scheduler that tested the wrong bank's window, or let a precharge cut into a burst, would show a gap one cycle short. A latency pipe tapped at the wrong stage would put the beats one cycle early or late, and it would break the seamless join of two back-to-back reads. With all four banks open, the bench waits for a refresh. It expects four precharges in consecutive cycles in ascending order, the refresh exactly TRP later, and a held request answered exactly TRFC after that. A controller that refreshed with a bank still open, or released traffic too early, shows up there.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } sdram_cmd_e;

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int ROW_W = 13,
  parameter int TRCD  = 3,
  parameter int TRP   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             col_ok_o,
  output logic             act_ok_o
);

  localparam int MAXD = (TRCD > TRP) ? TRCD : TRP;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] rcd_left;
  logic [CW-1:0] rp_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o   <= 1'b0;
      row_o    <= '0;
      rcd_left <= '0;
      rp_left  <= '0;
    end else begin
      if (act_i) begin
        open_o   <= 1'b1;
        row_o    <= row_i;
        rcd_left <= CW'(TRCD - 1);
      end else if (rcd_left != '0) begin
        rcd_left <= rcd_left - 1'b1;
      end
      if (pre_i) begin
        open_o  <= 1'b0;
        rp_left <= CW'(TRP - 1);
      end else if (rp_left != '0) begin
        rp_left <= rp_left - 1'b1;
      end
    end
  end

  assign col_ok_o = open_o && (rcd_left == '0);
  assign act_ok_o = !open_o && (rp_left == '0);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REFI = 976,
  parameter int TRFC = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  output logic due_o,
  output logic busy_o
);

  localparam int IW = $clog2(REFI);
  localparam int FW = $clog2(TRFC + 1);

  logic [IW-1:0] ival;
  logic [FW-1:0] rfc_left;
  logic          tick;

  assign tick = (ival == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ival     <= IW'(REFI - 1);
      due_o    <= 1'b0;
      rfc_left <= '0;
    end else begin
      ival <= tick ? IW'(REFI - 1) : ival - 1'b1;
      if (tick)       due_o <= 1'b1;
      else if (ref_i) due_o <= 1'b0;
      if (ref_i)                rfc_left <= FW'(TRFC - 1);
      else if (rfc_left != '0) rfc_left <= rfc_left - 1'b1;
    end
  end

  assign busy_o = (rfc_left != '0);

endmodule

// File: rtl/sdram_read_tagger.sv
module sdram_read_tagger #(
  parameter int BANK_W = 2,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              cas3_i,
  output logic              beat_valid_o,
  output logic [BANK_W-1:0] beat_bank_o
);

  localparam int BCW = $clog2(BURST + 1);

  logic [1:0]        pv;
  logic [BANK_W-1:0] pb [2];
  logic [BCW-1:0]    left;
  logic              start;
  logic [BANK_W-1:0] start_bank;

  assign start      = cas3_i ? pv[1] : pv[0];
  assign start_bank = cas3_i ? pb[1] : pb[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pv          <= '0;
      pb[0]       <= '0;
      pb[1]       <= '0;
      left        <= '0;
      beat_bank_o <= '0;
    end else begin
      pv    <= {pv[0], rd_i};
      pb[0] <= bank_i;
      pb[1] <= pb[0];
      if (start) begin
        left        <= BCW'(BURST);
        beat_bank_o <= start_bank;
      end else if (left != '0) begin
        left <= left - 1'b1;
      end
    end
  end

  assign beat_valid_o = (left != '0);

endmodule

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched #(
  parameter int NBANK = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 9,
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int TRFC  = 9,
  parameter int REFI  = 976,
  parameter int BURST = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cas3,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ready,
  output logic [3:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              rd_beat_valid,
  output logic [BANK_W-1:0] rd_beat_bank
);
  import sdram_sched_pkg::*;

  localparam int BUS_W = $clog2(BURST + 1);

  logic [NBANK-1:0] open_v, col_ok_v, act_ok_v;
  logic [ROW_W-1:0] row_a [NBANK];

  sdram_cmd_e        cmd_q, nxt_cmd;
  logic [BANK_W-1:0] bank_q, nxt_bank, low_bank;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [BUS_W-1:0]  bus_left;
  logic              bus_free, any_open, all_ready;
  logic              ref_due, ref_busy;

  genvar g;
  generate
    for (g = 0; g < NBANK; g++) begin : g_bank
      sdram_bank_track #(.ROW_W(ROW_W), .TRCD(TRCD), .TRP(TRP)) trk_i (
        .clk     (clk),
        .rst     (rst),
        .act_i   ((nxt_cmd == CMD_ACT) && (nxt_bank == BANK_W'(g))),
        .pre_i   ((nxt_cmd == CMD_PRE) && (nxt_bank == BANK_W'(g))),
        .row_i   (req_row),
        .open_o  (open_v[g]),
        .row_o   (row_a[g]),
        .col_ok_o(col_ok_v[g]),
        .act_ok_o(act_ok_v[g])
      );
    end
  endgenerate

  sdram_refresh_timer #(.REFI(REFI), .TRFC(TRFC)) rft_i (
    .clk   (clk),
    .rst   (rst),
    .ref_i (nxt_cmd == CMD_REF),
    .due_o (ref_due),
    .busy_o(ref_busy)
  );

  sdram_read_tagger #(.BANK_W(BANK_W), .BURST(BURST)) tag_i (
    .clk         (clk),
    .rst         (rst),
    .rd_i        (cmd_q == CMD_RD),
    .bank_i      (bank_q),
    .cas3_i      (cfg_cas3),
    .beat_valid_o(rd_beat_valid),
    .beat_bank_o (rd_beat_bank)
  );

  assign bus_free  = (bus_left == '0);
  assign all_ready = &act_ok_v;

  always_comb begin
    low_bank = '0;
    any_open = 1'b0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (open_v[i]) begin
        low_bank = BANK_W'(i);
        any_open = 1'b1;
      end
    end
  end

  always_comb begin
    nxt_cmd   = CMD_NOP;
    nxt_bank  = req_bank;
    nxt_addr  = '0;
    req_ready = 1'b0;
    if (!ref_busy) begin
      if (ref_due) begin
        if (bus_free) begin
          if (any_open) begin
            nxt_bank = low_bank;
            if (col_ok_v[low_bank]) nxt_cmd = CMD_PRE;
          end else if (all_ready) begin
            nxt_cmd = CMD_REF;
          end
        end
      end else if (req_valid) begin
        if (open_v[req_bank]) begin
          if (row_a[req_bank] == req_row) begin
            if (col_ok_v[req_bank] && bus_free) begin
              nxt_cmd  = req_write ? CMD_WR : CMD_RD;
              nxt_addr[COL_W-1:0] = req_col;
              req_ready = 1'b1;
            end
          end else if (col_ok_v[req_bank] && bus_free) begin
            nxt_cmd = CMD_PRE;
          end
        end else if (act_ok_v[req_bank]) begin
          nxt_cmd = CMD_ACT;
          nxt_addr[ROW_W-1:0] = req_row;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= CMD_NOP;
      bank_q   <= '0;
      addr_q   <= '0;
      bus_left <= '0;
    end else begin
      cmd_q  <= nxt_cmd;
      bank_q <= nxt_bank;
      addr_q <= nxt_addr;
      if ((nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR)) bus_left <= BUS_W'(BURST - 1);
      else if (bus_left != '0)                        bus_left <= bus_left - 1'b1;
    end
  end

  assign cmd_code = cmd_q;
  assign cmd_bank = bank_q;
  assign cmd_addr = addr_q;

endmodule

// File: rtl/sdram_cmd_sched_chk.sv
module sdram_cmd_sched_chk #(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int TRCD   = 3,
  parameter int TRP    = 3,
  parameter int TRFC   = 9,
  parameter int BURST  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cmd_code,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              req_ready
);
  import sdram_sched_pkg::*;

  localparam logic [15:0] SAT   = 16'hFFFF;
  localparam logic [15:0] K_RCD = 16'(TRCD);
  localparam logic [15:0] K_RP  = 16'(TRP);
  localparam logic [15:0] K_RFC = 16'(TRFC);
  localparam logic [15:0] K_BL  = 16'(BURST);

  logic [15:0]      since_act [NBANK];
  logic [15:0]      since_pre [NBANK];
  logic [15:0]      since_col, since_ref;
  logic [NBANK-1:0] open_m;
  logic             is_col, is_act, is_pre, is_ref;

  assign is_col = (cmd_code == CMD_RD) || (cmd_code == CMD_WR);
  assign is_act = (cmd_code == CMD_ACT);
  assign is_pre = (cmd_code == CMD_PRE);
  assign is_ref = (cmd_code == CMD_REF);

  function automatic logic [15:0] bump(input logic [15:0] v);
    return (v == SAT) ? SAT : v + 16'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBANK; i++) begin
        since_act[i] <= SAT;
        since_pre[i] <= SAT;
      end
      since_col <= SAT;
      since_ref <= SAT;
      open_m    <= '0;
    end else begin
      for (int i = 0; i < NBANK; i++) begin
        since_act[i] <= (is_act && cmd_bank == BANK_W'(i)) ? 16'd1 : bump(since_act[i]);
        since_pre[i] <= (is_pre && cmd_bank == BANK_W'(i)) ? 16'd1 : bump(since_pre[i]);
        if (is_act && cmd_bank == BANK_W'(i)) open_m[i] <= 1'b1;
        if (is_pre && cmd_bank == BANK_W'(i)) open_m[i] <= 1'b0;
      end
      since_col <= is_col ? 16'd1 : bump(since_col);
      since_ref <= is_ref ? 16'd1 : bump(since_ref);
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cmd_code inside {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF}); // R1
  AST_TRCD_MET: assert property (@(posedge clk) disable iff (rst)
    is_col |-> since_act[cmd_bank] >= K_RCD); // R2
  AST_COL_OPEN: assert property (@(posedge clk) disable iff (rst)
    is_col |-> open_m[cmd_bank]); // R3
  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (rst)
    is_act |-> !open_m[cmd_bank]); // R4
  AST_TRP_MET: assert property (@(posedge clk) disable iff (rst)
    is_act |-> since_pre[cmd_bank] >= K_RP); // R4
  AST_COL_SPACING: assert property (@(posedge clk) disable iff (rst)
    is_col |-> since_col >= K_BL); // R5
  AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> open_m == '0); // R9
  AST_RFC_QUIET: assert property (@(posedge clk) disable iff (rst)
    (since_ref < K_RFC) |-> cmd_code == CMD_NOP); // R10
  AST_READY_COL: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> is_col); // R11

endmodule

bind sdram_cmd_sched sdram_cmd_sched_chk #(
  .NBANK(NBANK), .BANK_W(BANK_W), .TRCD(TRCD), .TRP(TRP), .TRFC(TRFC), .BURST(BURST)
) chk_i (
  .clk(clk), .rst(rst), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .req_ready(req_ready)
);

// File: tb/sdram_cmd_sched_tb_top.sv
module sdram_cmd_sched_tb_top;
  import sdram_sched_pkg::*;

  localparam int NB = 4, RW = 4, CW = 4, BW = 2;
  localparam int T_RCD = 3, T_RP = 2, T_RFC = 6, T_REFI = 300, BL = 2;

  logic          clk = 1'b0, rst = 1'b1, cfg_cas3 = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic          req_ready, rd_beat_valid;
  logic [3:0]    cmd_code;
  logic [BW-1:0] cmd_bank, rd_beat_bank;
  logic [RW-1:0] cmd_addr;

  sdram_cmd_sched #(.NBANK(NB), .ROW_W(RW), .COL_W(CW), .TRCD(T_RCD), .TRP(T_RP),
                    .TRFC(T_RFC), .REFI(T_REFI), .BURST(BL)) dut_i (
    .clk(clk), .rst(rst), .cfg_cas3(cfg_cas3), .req_valid(req_valid),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_ready(req_ready), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .rd_beat_valid(rd_beat_valid), .rd_beat_bank(rd_beat_bank)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nvec = 0, nfail = 0;
  int l_cyc [1024], l_code [1024], l_bank [1024], l_addr [1024];
  int b_cyc [1024], b_bank [1024];
  int ln = 0, bn = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_code != CMD_NOP && ln < 1024) begin
        l_cyc[ln] = cyc; l_code[ln] = int'(cmd_code);
        l_bank[ln] = int'(cmd_bank); l_addr[ln] = int'(cmd_addr);
        ln++;
      end
      if (rd_beat_valid && bn < 1024) begin
        b_cyc[bn] = cyc; b_bank[bn] = int'(rd_beat_bank);
        bn++;
      end
    end
  end

  function automatic int find(int code, int from);
    for (int i = from; i < ln; i++) if (l_code[i] == code) return i;
    return -1;
  endfunction
  function automatic int lc(int i); return (i >= 0) ? l_cyc[i] : -1000; endfunction
  function automatic int lb(int i); return (i >= 0) ? l_bank[i] : -1; endfunction
  function automatic int la(int i); return (i >= 0) ? l_addr[i] : -1; endfunction

  task automatic chk(string req, string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_req(input int w, input int b, input int row, input int col, output int ret);
    bit got;
    got = 1'b0;
    req_valid = 1'b1; req_write = w[0];
    req_bank = BW'(b); req_row = RW'(row); req_col = CW'(col);
    while (!got) begin
      #1;
      if (req_ready) got = 1'b1;
      step();
    end
    req_valid = 1'b0;
    ret = cyc;
  endtask

  task automatic wait_ref(input int from, output int idx);
    idx = find(int'(CMD_REF), from);
    while (idx < 0) begin
      step();
      idx = find(int'(CMD_REF), from);
    end
  endtask

  task automatic sync_ref();
    int k;
    wait_ref(ln, k);
    repeat (T_RFC + 2) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL all-requirements watchdog: actual cycle %0d expected below %0d", cyc, 200000);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int ret, n0, nb0, r1, r2, ia, ic1, ic2, ic3, ip, ia2, cl, colcode, row_a, col_a;
    int cols [3];
    int pi [4];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    chk("R1", "cmd after reset", int'(cmd_code), 7);
    chk("R1", "ready after reset", int'(req_ready), 0);
    chk("R1", "beat after reset", int'(rd_beat_valid), 0);

    for (int cas = 0; cas < 2; cas++) begin
      for (int b = 0; b < NB; b++) begin
        for (int w = 0; w < 2; w++) begin
          cfg_cas3 = cas[0];
          cl = cas ? 3 : 2;
          colcode = w ? int'(CMD_WR) : int'(CMD_RD);
          row_a = (b * 3 + 1) & 7;
          col_a = b * 3 + w + 1;
          sync_ref();
          n0 = ln; nb0 = bn;
          // closed bank
          do_req(w, b, row_a, col_a, ret);
          ia = find(int'(CMD_ACT), n0);
          ic1 = find(colcode, n0);
          chk("R2", "act bank", lb(ia), b);
          chk("R2", "act row", la(ia), row_a);
          chk("R2", "act to col gap", lc(ic1) - lc(ia), T_RCD);
          chk("R3", "col addr", la(ic1), col_a);
          chk("R11", "col cycle after ready", lc(ic1), ret);
          cols[0] = lc(ic1);
          // row hit
          do_req(w, b, row_a, col_a + 1, ret);
          ic2 = find(colcode, ic1 + 1);
          chk("R3", "no act on hit", find(int'(CMD_ACT), ic1 + 1), -1);
          chk("R3", "hit col addr", la(ic2), col_a + 1);
          chk("R7", "col spacing on hit", lc(ic2) - lc(ic1), BL);
          cols[1] = lc(ic2);
          // row miss
          do_req(w, b, row_a ^ 8, col_a, ret);
          ip  = find(int'(CMD_PRE), ic2 + 1);
          ia2 = find(int'(CMD_ACT), ic2 + 1);
          ic3 = find(colcode, ic2 + 1);
          chk("R5", "pre after burst", lc(ip) - lc(ic2), BL);
          chk("R4", "pre bank", lb(ip), b);
          chk("R4", "pre to act gap", lc(ia2) - lc(ip), T_RP);
          chk("R4", "miss act row", la(ia2), row_a ^ 8);
          chk("R2", "miss act to col gap", lc(ic3) - lc(ia2), T_RCD);
          cols[2] = lc(ic3);
          repeat (10) step();
          if (w == 0) begin
            chk("R6", "beat count", bn - nb0, 3 * BL);
            if (bn - nb0 == 3 * BL) begin
              for (int r = 0; r < 3; r++) begin
                for (int k = 0; k < BL; k++) begin
                  chk("R6", "beat cycle", b_cyc[nb0 + r * BL + k], cols[r] + cl + k);
                  chk("R6", "beat bank", b_bank[nb0 + r * BL + k], b);
                end
              end
              chk("R7", "seamless beats", b_cyc[nb0 + 2 * BL - 1] - b_cyc[nb0], 2 * BL - 1);
            end
          end else begin
            chk("R6", "no beat on write", bn - nb0, 0);
          end
        end
      end
    end

    // bank independence and refresh sequencing
    cfg_cas3 = 1'b0;
    sync_ref();
    n0 = ln;
    do_req(0, 0, 1, 0, ret);
    do_req(0, 1, 2, 0, ret);
    ic1 = find(int'(CMD_RD), n0);
    ia  = find(int'(CMD_ACT), ic1 + 1);
    chk("R12", "other bank act right after col", lc(ia) - lc(ic1), 1);
    chk("R12", "other bank act bank", lb(ia), 1);
    do_req(1, 2, 3, 0, ret);
    do_req(0, 3, 4, 0, ret);
    n0 = ln;
    wait_ref(n0, r1);
    for (int i = 0; i < 4; i++) pi[i] = find(int'(CMD_PRE), (i == 0) ? n0 : pi[i-1] + 1);
    for (int i = 0; i < 4; i++) begin
      chk("R9", "pre order bank", lb(pi[i]), i);
      chk("R12", "pre consecutive", lc(pi[i]) - lc(pi[0]), i);
    end
    chk("R9", "ref after last pre", lc(r1) - lc(pi[3]), T_RP);
    n0 = ln;
    do_req(0, 2, 5, 1, ret);
    ia = find(int'(CMD_ACT), n0);
    chk("R10", "first cmd after ref", lc(ia) - lc(r1), T_RFC);
    chk("R10", "held act bank", lb(ia), 2);

    // refresh interval while idle
    sync_ref();
    n0 = ln;
    wait_ref(n0, r1);
    wait_ref(r1 + 1, r2);
    chk("R8", "refresh spacing", lc(r2) - lc(r1), T_REFI);
    chk("R8", "idle between refreshes", r2 - r1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule